// File: doc/BRIEF.md
# Arbitrating Bus Frame Transmitter

This block sends frames onto a shared differential bus on which several nodes may start at the same moment. The first character of every frame is the sender's address, and the bus decides who transmits by comparing these addresses one bit at a time. Dominant is logic 0 and recessive is logic 1. During the address character the block drives the line only for zero bits and releases it for one bits, at a slow bit rate. It reads every bit back through its receiver. A node that sends a one and reads back a zero has lost. It releases the bus at once, waits until the bus has been quiet long enough, and tries again on its own.

The node that wins keeps the bus. It then drives the line in both directions, push-pull, for the rest of the frame at a faster bit rate. Every character is 8N1: a zero start bit, eight data bits with the LSB first, and a one stop bit.

The host holds a frame request and presents one byte at a time. Each byte stays on the input until the block acknowledges it. The first byte is acknowledged only after arbitration is won, so a retry needs nothing from the host.

Top module: `arb_frame_tx`

## Requirements
- R1: While reset is active, and whenever no frame is in progress, `tx_o` is 1 and `tx_en_o` is 0, and `byte_ack_o`, `lost_o`, `fail_o` and `done_o` are 0.
- R2: Each character goes out as 10 bits: a 0 start bit, the 8 data bits with bit 0 first, then a 1 stop bit. The first character of a frame uses DIV_LO clocks per bit.
- R3: During the first character, `tx_en_o` is 1 exactly while the bit being sent is 0, so recessive bits are released and not driven.
- R4: After the first character is won, every later character of the frame uses DIV_HI clocks per bit. `tx_en_o` stays 1 for the whole remainder of the frame, including the one-clock gap between characters.
- R5: In each bit of the first character the synchronized readback is compared at clock SAMPLE_PT of the bit. If a 1 was sent and a 0 is read, `lost_o` pulses for one clock, `tx_en_o` drops, and that attempt sends nothing more.
- R6: A frame starts only after the synchronized readback has been 1 for IDLE_BITS*DIV_LO consecutive clocks. The start bit appears between IDLE_BITS*DIV_LO and IDLE_BITS*DIV_LO+4 clocks after the bus is released.
- R7: After a loss the block retries the same first byte under the same idle rule, with no host action. Each byte, including the first, is acknowledged exactly once.
- R8: When an attempt is lost and MAX_RETRY retries have already been used, `fail_o` pulses together with `lost_o`. Nothing is acknowledged, and the line stays released until `frame_req_i` has gone low.
- R9: `byte_ack_o` pulses for one clock at the end of each character's stop bit. `done_o` pulses in the same clock as the acknowledge of the byte marked last.
- R10: A 0 sent during arbitration that reads back as 1 is not a loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_req_i | input | 1 | Held high while a frame is pending |
| byte_i | input | 8 | Current byte of the frame; the first byte is the sender address |
| byte_last_i | input | 1 | Marks `byte_i` as the final byte of the frame |
| byte_ack_o | output | 1 | One-clock pulse when `byte_i` has been sent |
| rx_i | input | 1 | Receiver output, the bus level read back (asynchronous) |
| tx_o | output | 1 | Transmit data to the line driver |
| tx_en_o | output | 1 | Line driver enable |
| lost_o | output | 1 | One-clock pulse on lost arbitration |
| fail_o | output | 1 | One-clock pulse when the retry limit is exhausted |
| done_o | output | 1 | One-clock pulse when the frame is complete |

## Verification
The bench models the wired bus with a second sender that starts together with the block, and runs the following patterns:

- An uncontested frame and a one-byte frame show the plain serialisation and the switch in bit rate.
- A rival with a lower address beats the block on the first data bit. This shows the release, the automatic retry and that the first byte is acknowledged only once.
- A rival that loses to the block shows that a winning frame goes through undisturbed.
- A rival that wins on every attempt drives the block into its retry limit.
- A bus held low, and then a bus forced high, separate the idle-time rule from the rule that only a one read as zero counts as a loss.

// File: rtl/arb_tx_pkg.sv
package arb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_LOAD,
    ST_DATA,
    ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/bus_idle_mon.sv
module bus_idle_mon #(
  parameter int IDLE_CLKS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_sync_o,
  output logic idle_o
);
  localparam int IW = $clog2(IDLE_CLKS + 1);
  localparam logic [IW-1:0] IDLE_END = IW'(IDLE_CLKS);

  logic [1:0]    sync_q;
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (!sync_q[1])            cnt_q <= '0;
      else if (cnt_q != IDLE_END) cnt_q <= cnt_q + IW'(1);
    end
  end

  assign rx_sync_o = sync_q[1];
  assign idle_o    = (cnt_q == IDLE_END);
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int DIV_LO    = 16,
  parameter int DIV_HI    = 4,
  parameter int SAMPLE_PT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic bit_end_o,
  output logic sample_o
);
  localparam int CW = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
  localparam logic [CW-1:0] LO_END = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] HI_END = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] SMP    = CW'(SAMPLE_PT);

  logic [CW-1:0] cnt_q;

  assign bit_end_o = run_i && (cnt_q == (fast_i ? HI_END : LO_END));
  assign sample_o  = run_i && !fast_i && (cnt_q == SMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/arb_frame_tx.sv
module arb_frame_tx
  import arb_tx_pkg::*;
#(
  parameter int DIV_LO    = 16,
  parameter int DIV_HI    = 4,
  parameter int SAMPLE_PT = 12,
  parameter int IDLE_BITS = 4,
  parameter int MAX_RETRY = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_req_i,
  input  logic [7:0] byte_i,
  input  logic       byte_last_i,
  output logic       byte_ack_o,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       tx_en_o,
  output logic       lost_o,
  output logic       fail_o,
  output logic       done_o
);
  localparam int IDLE_CLKS = IDLE_BITS * DIV_LO;
  localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [RW-1:0] RETRY_MAX = RW'(MAX_RETRY);

  tx_state_e     st_q;
  logic [9:0]    sh_q;
  logic [3:0]    bit_q;
  logic [RW-1:0] retry_q;
  logic          ack_q, lost_q, fail_q, done_q;
  logic          rx_s, bus_idle, bit_end, sample, char_end, run, fast;

  assign run      = (st_q == ST_ARB) || (st_q == ST_DATA);
  assign fast     = (st_q == ST_DATA);
  assign char_end = bit_end && (bit_q == 4'd9);

  bus_idle_mon #(.IDLE_CLKS(IDLE_CLKS)) i_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_i),
    .rx_sync_o(rx_s),
    .idle_o   (bus_idle)
  );

  bit_timer #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SAMPLE_PT(SAMPLE_PT)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .fast_i   (fast),
    .bit_end_o(bit_end),
    .sample_o (sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sh_q    <= '1;
      bit_q   <= '0;
      retry_q <= '0;
      ack_q   <= 1'b0;
      lost_q  <= 1'b0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      lost_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (frame_req_i) begin
          st_q    <= ST_WAIT;
          retry_q <= '0;
        end
        ST_WAIT: begin
          if (!frame_req_i) st_q <= ST_IDLE;
          else if (bus_idle) begin
            st_q  <= ST_ARB;
            sh_q  <= {1'b1, byte_i, 1'b0};
            bit_q <= '0;
          end
        end
        ST_ARB: begin
          if (sample && sh_q[0] && !rx_s) begin
            // recessive sent, dominant seen: back off
            lost_q <= 1'b1;
            sh_q   <= '1;
            if (retry_q == RETRY_MAX) begin
              fail_q <= 1'b1;
              st_q   <= ST_HOLD;
            end else begin
              retry_q <= retry_q + RW'(1);
              st_q    <= ST_WAIT;
            end
          end else if (char_end) begin
            ack_q <= 1'b1;
            if (byte_last_i) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else st_q <= ST_LOAD;
          end else if (bit_end) begin
            sh_q  <= {1'b1, sh_q[9:1]};
            bit_q <= bit_q + 4'd1;
          end
        end
        ST_LOAD: begin
          sh_q  <= {1'b1, byte_i, 1'b0};
          bit_q <= '0;
          st_q  <= ST_DATA;
        end
        ST_DATA: begin
          if (char_end) begin
            ack_q <= 1'b1;
            if (byte_last_i) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else st_q <= ST_LOAD;
          end else if (bit_end) begin
            sh_q  <= {1'b1, sh_q[9:1]};
            bit_q <= bit_q + 4'd1;
          end
        end
        ST_HOLD: if (!frame_req_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_o    = 1'b1;
    tx_en_o = 1'b0;
    unique case (st_q)
      ST_ARB: begin
        tx_o    = sh_q[0];
        tx_en_o = !sh_q[0];
      end
      ST_DATA: begin
        tx_o    = sh_q[0];
        tx_en_o = 1'b1;
      end
      ST_LOAD: tx_en_o = 1'b1;
      default: ;
    endcase
  end

  assign byte_ack_o = ack_q;
  assign lost_o     = lost_q;
  assign fail_o     = fail_q;
  assign done_o     = done_q;
endmodule

// File: rtl/arb_frame_tx_chk.sv
module arb_frame_tx_chk
  import arb_tx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input tx_state_e st_i,
  input logic      idle_i,
  input logic      tx_o,
  input logic      tx_en_o,
  input logic      byte_ack_o,
  input logic      lost_o,
  input logic      fail_o,
  input logic      done_o
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> (tx_o && !tx_en_o)); // R1
  AST_ARB_OPEN_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ARB) |-> (tx_en_o == !tx_o)); // R3
  AST_PUSH_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DATA || st_i == ST_LOAD) |-> tx_en_o); // R4
  AST_LOST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> !lost_o); // R5
  AST_LOST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !tx_en_o); // R5
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ARB && $past(st_i) == ST_WAIT) |-> $past(idle_i)); // R6
  AST_FAIL_WITH_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (lost_o && !byte_ack_o)); // R8
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ack_o |=> !byte_ack_o); // R9
  AST_DONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> byte_ack_o); // R9
endmodule

bind arb_frame_tx arb_frame_tx_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .st_i      (st_q),
  .idle_i    (bus_idle),
  .tx_o      (tx_o),
  .tx_en_o   (tx_en_o),
  .byte_ack_o(byte_ack_o),
  .lost_o    (lost_o),
  .fail_o    (fail_o),
  .done_o    (done_o)
);

// File: tb/test_arb_frame_tx.sv
module test_arb_frame_tx;
  localparam int DIV_LO    = 16;
  localparam int DIV_HI    = 4;
  localparam int SAMPLE_PT = 12;
  localparam int IDLE_BITS = 4;
  localparam int MAX_RETRY = 3;
  localparam int IDLE_CLKS = IDLE_BITS * DIV_LO;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       frame_req = 1'b0;
  logic [7:0] byte_v = 8'h00;
  logic       last = 1'b0;
  logic       comp_low = 1'b0;
  logic       force_hi = 1'b0;
  logic       tx, tx_en, ack, lost, fail, done;

  wire dut_line = tx_en ? tx : 1'b1;
  wire bus      = force_hi | (!comp_low & dut_line);

  arb_frame_tx #(
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SAMPLE_PT(SAMPLE_PT),
    .IDLE_BITS(IDLE_BITS), .MAX_RETRY(MAX_RETRY)
  ) i_arb_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .frame_req_i(frame_req), .byte_i(byte_v),
    .byte_last_i(last), .byte_ack_o(ack), .rx_i(bus), .tx_o(tx),
    .tx_en_o(tx_en), .lost_o(lost), .fail_o(fail), .done_o(done)
  );

  typedef struct packed {
    logic [7:0] data;
    logic       last;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] fbytes[$];
  int checks = 0, errors = 0;
  int n_lost = 0, n_fail = 0, n_done = 0, n_ack = 0;

  always @(negedge clk) if (rst_n) begin
    if (lost) n_lost++;
    if (fail) n_fail++;
    if (done) n_done++;
    if (ack)  n_ack++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: pushes the expected characters, then feeds bytes on acknowledge
  task automatic send_frame(input bit expect_fail);
    int idx = 0;
    if (!expect_fail)
      for (int i = 0; i < fbytes.size(); i++)
        exp_q.push_back('{data: fbytes[i], last: (i == fbytes.size() - 1)});
    @(negedge clk);
    frame_req = 1'b1;
    byte_v    = fbytes[0];
    last      = (fbytes.size() == 1);
    forever begin
      @(negedge clk);
      if (fail) break;
      if (ack) begin
        idx++;
        if (idx == fbytes.size()) break;
        byte_v = fbytes[idx];
        last   = (idx == fbytes.size() - 1);
      end
    end
    frame_req = 1'b0;
    last      = 1'b0;
  endtask

  // rival sender, hard-synchronised to the block's start bit
  task automatic comp_char(input logic [7:0] addr);
    logic [9:0] f = {1'b1, addr, 1'b0};
    while (tx_en !== 1'b1) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      comp_low = !f[k];
      for (int j = 0; j < DIV_LO; j++) begin
        if (j == 8 && f[k] && bus == 1'b0) begin
          comp_low = 1'b0;
          return;
        end
        @(negedge clk);
      end
    end
    comp_low = 1'b0;
  endtask

  task automatic score(input logic [9:0] f, input bit mode_ok, input bit slow,
                       output bit is_last);
    exp_t e;
    is_last = 1'b1;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2", "unexpected character", int'(f[8:1]), 0);
      return;
    end
    e = exp_q.pop_front();
    is_last = e.last;
    chk(f[8:1] == e.data, "R2", "data byte", int'(f[8:1]), int'(e.data));
    chk(f[0] == 1'b0 && f[9] == 1'b1, "R2", "start/stop", int'(f), 32'h200);
    if (slow) chk(mode_ok, "R3", "enable only on zero bits", 0, 1);
    else      chk(mode_ok, "R4", "push-pull enable held", 0, 1);
  endtask

  // monitor: decodes the block's own line
  initial begin
    logic [9:0] f;
    bit ok, is_last;
    int lost0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (dut_line !== 1'b0) continue;
      lost0 = n_lost;
      ok = 1'b1;
      for (int k = 0; k < 10; k++) begin
        repeat (DIV_LO / 2) @(negedge clk);
        f[k] = dut_line;
        if (tx_en !== !tx) ok = 1'b0;
        repeat (DIV_LO / 2) @(negedge clk);
      end
      if (n_lost != lost0) continue;
      score(f, ok, 1'b1, is_last);
      while (!is_last) begin
        while (dut_line !== 1'b0) @(negedge clk);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
          repeat (DIV_HI / 2) @(negedge clk);
          f[k] = dut_line;
          if (tx_en !== 1'b1) ok = 1'b0;
          repeat (DIV_HI / 2) @(negedge clk);
        end
        score(f, ok, 1'b0, is_last);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, d0, l0, f0, j;
    bit quiet;

    repeat (3) @(negedge clk);
    chk(tx === 1'b1 && tx_en === 1'b0, "R1", "line in reset", int'({tx, tx_en}), 2);
    chk({ack, lost, fail, done} === 4'b0, "R1", "pulses in reset",
        int'({ack, lost, fail, done}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx === 1'b1 && tx_en === 1'b0, "R1", "line idle", int'({tx, tx_en}), 2);

    // uncontested four-byte frame
    fbytes.delete();
    fbytes.push_back(8'hA5); fbytes.push_back(8'h3C);
    fbytes.push_back(8'hFF); fbytes.push_back(8'h00);
    a0 = n_ack; d0 = n_done; l0 = n_lost;
    send_frame(1'b0);
    repeat (20) @(negedge clk);
    chk(n_ack - a0 == 4, "R9", "acks per frame", n_ack - a0, 4);
    chk(n_done - d0 == 1, "R9", "done per frame", n_done - d0, 1);
    chk(n_lost == l0, "R5", "no loss uncontested", n_lost - l0, 0);
    chk(tx === 1'b1 && tx_en === 1'b0, "R1", "line after frame", int'({tx, tx_en}), 2);

    // one-byte frame
    fbytes.delete();
    fbytes.push_back(8'h5A);
    a0 = n_ack; d0 = n_done;
    send_frame(1'b0);
    repeat (20) @(negedge clk);
    chk(n_ack - a0 == 1 && n_done - d0 == 1, "R9", "single byte ack/done",
        n_ack - a0, 1);

    // rival 0x12 beats 0x13 on data bit 0, then the block retries
    fbytes.delete();
    fbytes.push_back(8'h13); fbytes.push_back(8'h77); fbytes.push_back(8'h81);
    a0 = n_ack; l0 = n_lost; d0 = n_done;
    fork
      send_frame(1'b0);
      comp_char(8'h12);
    join
    repeat (20) @(negedge clk);
    chk(n_lost - l0 == 1, "R5", "one loss flagged", n_lost - l0, 1);
    chk(n_ack - a0 == 3, "R7", "first byte acked once", n_ack - a0, 3);
    chk(n_done - d0 == 1, "R7", "retried frame done", n_done - d0, 1);

    // rival 0x21 loses to 0x20
    fbytes.delete();
    fbytes.push_back(8'h20); fbytes.push_back(8'hC3);
    l0 = n_lost; a0 = n_ack;
    fork
      send_frame(1'b0);
      comp_char(8'h21);
    join
    repeat (20) @(negedge clk);
    chk(n_lost == l0, "R5", "winner not flagged", n_lost - l0, 0);
    chk(n_ack - a0 == 2, "R9", "winner acks", n_ack - a0, 2);

    // retry limit: rival wins every attempt
    fbytes.delete();
    fbytes.push_back(8'h13); fbytes.push_back(8'h44);
    l0 = n_lost; f0 = n_fail; a0 = n_ack;
    fork
      send_frame(1'b1);
      for (int i = 0; i <= MAX_RETRY; i++) comp_char(8'h12);
    join
    quiet = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (tx_en !== 1'b0) quiet = 1'b0;
    end
    chk(n_lost - l0 == MAX_RETRY + 1, "R8", "losses before fail", n_lost - l0,
        MAX_RETRY + 1);
    chk(n_fail - f0 == 1, "R8", "fail pulses", n_fail - f0, 1);
    chk(n_ack == a0, "R8", "no ack on failure", n_ack - a0, 0);
    chk(quiet, "R8", "line released after fail", 0, 1);

    // recovery after failure
    fbytes.delete();
    fbytes.push_back(8'h0F);
    d0 = n_done;
    send_frame(1'b0);
    repeat (20) @(negedge clk);
    chk(n_done - d0 == 1, "R7", "frame after failure", n_done - d0, 1);

    // idle rule: bus held low, then released
    fbytes.delete();
    fbytes.push_back(8'h66); fbytes.push_back(8'h99);
    comp_low = 1'b1;
    fork
      send_frame(1'b0);
      begin
        quiet = 1'b1;
        repeat (200) begin
          @(negedge clk);
          if (tx_en !== 1'b0) quiet = 1'b0;
        end
        chk(quiet, "R6", "no start on busy bus", 0, 1);
        comp_low = 1'b0;
        j = 0;
        while (tx_en !== 1'b1 && j < 500) begin
          @(negedge clk);
          j++;
        end
        chk(j >= IDLE_CLKS && j <= IDLE_CLKS + 4, "R6", "start delay after release",
            j, IDLE_CLKS + 3);
      end
    join
    repeat (20) @(negedge clk);

    // sent zero read as one is not a loss
    fbytes.delete();
    fbytes.push_back(8'h00); fbytes.push_back(8'h55);
    force_hi = 1'b1;
    l0 = n_lost; d0 = n_done;
    send_frame(1'b0);
    repeat (20) @(negedge clk);
    force_hi = 1'b0;
    chk(n_lost == l0, "R10", "zero read high ignored", n_lost - l0, 0);
    chk(n_done - d0 == 1, "R10", "frame completes", n_done - d0, 1);

    chk(exp_q.size() == 0, "R2", "characters still expected", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule